// File: doc/BRIEF.md
# Half-Rate Speculative Decision Feedback Equalizer

This block recovers data bits from a stream of signed, quantized receive samples. It takes two samples on every clock: one for an even-indexed bit and one for the odd-indexed bit that follows it. Each decision cancels the intersymbol interference left by the five previously decided bits, using a set of signed tap weights.

The first post-cursor tap is not in the feedback loop. Each half forms two corrected sums in parallel: one assumes the previous bit was +1 and the other assumes it was -1. Each sum is sliced. The previous bit then picks one of the two slicer results through a two-way mux. Taps two to five are subtracted in the usual way, using the history of decided bits.

Both decisions of a pair are settled in the same clock. The odd half uses the even decision that has just been selected. A valid strobe marks the cycles that carry new samples. The decided bits and a five-bit history are registered at the outputs.

Top module: `spec_dfe_hr`

## Requirements
- R1: On a clock edge with `valid_i` high, the even and odd decisions for that sample pair appear on `dec_even_o` and `dec_odd_o` after that same edge. Both are decided within the one cycle.
- R2: Each half forms two sums in parallel, `x - H1 - isi` and `x + H1 - isi`, where `isi` is the correction from taps two to five. A slicer gives 1 when its sum is greater than or equal to zero, and 0 when the sum is negative.
- R3: The bit just before the current one selects the slicer result: 1 selects the `-H1` sum and 0 selects the `+H1` sum. For the even bit this is the odd bit of the previous pair (`hist_o[0]`). For the odd bit it is the even bit of the same pair.
- R4: Tap Hk, for k from 2 to 5, is subtracted as Hk times the bit decided k bit-times earlier. In that product a 1 counts as +1 and a 0 counts as -1.
- R5: After each valid cycle, `hist_o[0]` holds the new odd bit and `hist_o[1]` holds the new even bit. `hist_o[4:2]` holds the previous `hist_o[2:0]`. So `hist_o[j]` is the bit decided j+1 bit-times before the next even bit.
- R6: While `valid_i` is low, `dec_even_o`, `dec_odd_o` and `hist_o` keep their values, whatever the sample inputs do.
- R7: Reset clears the decisions and the history to zero. Zero history bits act as -1 in the next decisions.
- R8: Samples and taps are 8-bit two's complement values. Tap Hk sits in `coef_i[8k-1:8k-8]`. All sums are kept at full precision, with no wrap and no saturation, even when every input is at its most negative or most positive value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | New sample pair present this cycle |
| samp_even_i | input | 8 | Signed sample for the even bit |
| samp_odd_i | input | 8 | Signed sample for the odd bit |
| coef_i | input | 40 | Signed taps H1..H5; Hk in bits [8k-1:8k-8] |
| dec_even_o | output | 1 | Registered even decision |
| dec_odd_o | output | 1 | Registered odd decision |
| hist_o | output | 5 | Decided bit history, bit 0 most recent |

## Verification
The bench targets these cases:
- A sum of exactly zero, to catch a design that slices it to 0.
- Pairs where only H1 is set, to catch a design that swaps the roles of the speculative paths or feeds the odd half a stale previous bit in place of the fresh even decision.
- A lone H5 tap, and a lone H2 tap, after a reset and after shifting history. A design that misaligns the history, or treats cleared bits as +1, gives wrong decisions here.
- Full-scale negative and positive samples and taps, to expose sums that are too narrow and wrap.
- Idle cycles with changing samples, to show whether the outputs drift.

// File: rtl/spec_dfe_pkg.sv
package spec_dfe_pkg;

  // Decisions produced per clock (half rate: even and odd).
  localparam int unsigned LANES_PER_CLK = 2;

  // Accumulator width that holds a sample plus all tap terms without wrap.
  function automatic int unsigned acc_width(input int unsigned samp_w,
                                            input int unsigned coef_w,
                                            input int unsigned taps);
    int unsigned widest;
    widest = (samp_w > coef_w) ? samp_w : coef_w;
    return widest + $clog2(taps + 1) + 1;
  endfunction

endpackage

// File: rtl/spec_dfe_isi.sv
// Subtracts taps 2..NUM_TAPS from a sample, using past decisions as +/-1.
// past[k-1] is the decision k bit-times before the current one; past[0] is
// left to the speculative stage and is not used here.
module spec_dfe_isi #(
  parameter int unsigned SAMPLE_W = 8,
  parameter int unsigned COEF_W   = 8,
  parameter int unsigned NUM_TAPS = 5,
  parameter int unsigned ACC_W    = 12
) (
  input  logic [SAMPLE_W-1:0]        samp,
  input  logic [NUM_TAPS*COEF_W-1:0] coef,
  input  logic [NUM_TAPS-1:0]        past,
  output logic signed [ACC_W-1:0]    base
);

  // One signed term per tap: +Hk when the past bit is 1, -Hk when it is 0.
  function automatic logic signed [ACC_W-1:0] tap_term(input logic [COEF_W-1:0] c,
                                                       input logic b);
    logic signed [ACC_W-1:0] ext;
    ext = {{(ACC_W-COEF_W){c[COEF_W-1]}}, c};
    return b ? ext : -ext;
  endfunction

  logic signed [ACC_W-1:0] term [NUM_TAPS];

  // The H1 slot carries no term: that tap is resolved by speculation.
  assign term[0] = '0;

  for (genvar k = 1; k < NUM_TAPS; k++) begin : g_tap
    assign term[k] = tap_term(coef[k*COEF_W +: COEF_W], past[k]);
  end

  always_comb begin
    base = {{(ACC_W-SAMPLE_W){samp[SAMPLE_W-1]}}, samp};
    for (int k = 1; k < NUM_TAPS; k++) begin
      base = base - term[k];
    end
  end

endmodule

// File: rtl/spec_dfe_slice2.sv
// Two speculative slicers for the first tap and the mux that picks one.
module spec_dfe_slice2 #(
  parameter int unsigned COEF_W = 8,
  parameter int unsigned ACC_W  = 12
) (
  input  logic signed [ACC_W-1:0] base,
  input  logic [COEF_W-1:0]       h1,
  input  logic                    prev,
  output logic                    slice_up,
  output logic                    slice_dn,
  output logic                    dec
);

  // Slicer: 1 for a sum at or above zero.
  function automatic logic slice(input logic signed [ACC_W-1:0] s);
    return ~s[ACC_W-1];
  endfunction

  logic signed [ACC_W-1:0] h1_ext;
  logic signed [ACC_W-1:0] sum_up;  // previous bit assumed +1
  logic signed [ACC_W-1:0] sum_dn;  // previous bit assumed -1

  assign h1_ext   = {{(ACC_W-COEF_W){h1[COEF_W-1]}}, h1};
  assign sum_up   = base - h1_ext;
  assign sum_dn   = base + h1_ext;
  assign slice_up = slice(sum_up);
  assign slice_dn = slice(sum_dn);
  assign dec      = prev ? slice_up : slice_dn;

endmodule

// File: rtl/spec_dfe_hist.sv
// Output registers: per-lane decisions and the shifted bit history.
module spec_dfe_hist #(
  parameter int unsigned HIST_W = 5,
  parameter int unsigned LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic [LANES-1:0]  cur,    // cur[0] oldest of the group
  output logic [LANES-1:0]  dec_q,
  output logic [HIST_W-1:0] hist_q
);

  logic [HIST_W-1:0] hist_nxt;

  // Newest bit lands in position 0; older entries move up by LANES.
  for (genvar j = 0; j < HIST_W; j++) begin : g_nxt
    if (j < LANES) begin : g_new
      assign hist_nxt[j] = cur[LANES-1-j];
    end else begin : g_old
      assign hist_nxt[j] = hist_q[j-LANES];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      dec_q  <= '0;
    end else if (valid) begin
      hist_q <= hist_nxt;
      dec_q  <= cur;
    end
  end

endmodule

// File: rtl/spec_dfe_hr.sv
// Half-rate decision feedback equalizer with the first tap speculated.
module spec_dfe_hr #(
  parameter int unsigned SAMPLE_W = 8,
  parameter int unsigned COEF_W   = 8,
  parameter int unsigned NUM_TAPS = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        valid_i,
  input  logic [SAMPLE_W-1:0]         samp_even_i,
  input  logic [SAMPLE_W-1:0]         samp_odd_i,
  input  logic [NUM_TAPS*COEF_W-1:0]  coef_i,
  output logic                        dec_even_o,
  output logic                        dec_odd_o,
  output logic [NUM_TAPS-1:0]         hist_o
);

  localparam int unsigned LANES = spec_dfe_pkg::LANES_PER_CLK;
  localparam int unsigned ACC_W = spec_dfe_pkg::acc_width(SAMPLE_W, COEF_W, NUM_TAPS);

  logic [SAMPLE_W-1:0]     lane_samp [LANES];
  logic [NUM_TAPS-1:0]     lane_past [LANES];
  logic signed [ACC_W-1:0] lane_base [LANES];
  logic                    lane_up_w [LANES];
  logic                    lane_dn_w [LANES];
  logic                    lane_dec_w[LANES];

  // Named probes for the checker (bit L belongs to lane L).
  logic [LANES-1:0] lane_up;
  logic [LANES-1:0] lane_dn;
  logic [LANES-1:0] lane_prev;
  logic [LANES-1:0] lane_dec;
  logic [LANES-1:0] dec_q;

  assign lane_samp[0] = samp_even_i;
  assign lane_samp[1] = samp_odd_i;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    // Past bit k bit-times back: from this cycle's earlier lanes, else history.
    for (genvar k = 1; k <= NUM_TAPS; k++) begin : g_past
      if (k <= l) begin : g_cur
        assign lane_past[l][k-1] = lane_dec_w[l-k];
      end else begin : g_hist
        assign lane_past[l][k-1] = hist_o[k-l-1];
      end
    end

    spec_dfe_isi #(
      .SAMPLE_W (SAMPLE_W),
      .COEF_W   (COEF_W),
      .NUM_TAPS (NUM_TAPS),
      .ACC_W    (ACC_W)
    ) isi_i (
      .samp (lane_samp[l]),
      .coef (coef_i),
      .past (lane_past[l]),
      .base (lane_base[l])
    );

    spec_dfe_slice2 #(
      .COEF_W (COEF_W),
      .ACC_W  (ACC_W)
    ) slc_i (
      .base     (lane_base[l]),
      .h1       (coef_i[COEF_W-1:0]),
      .prev     (lane_past[l][0]),
      .slice_up (lane_up_w[l]),
      .slice_dn (lane_dn_w[l]),
      .dec      (lane_dec_w[l])
    );

    assign lane_up[l]   = lane_up_w[l];
    assign lane_dn[l]   = lane_dn_w[l];
    assign lane_prev[l] = lane_past[l][0];
    assign lane_dec[l]  = lane_dec_w[l];
  end

  spec_dfe_hist #(
    .HIST_W (NUM_TAPS),
    .LANES  (LANES)
  ) hist_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .valid  (valid_i),
    .cur    (lane_dec),
    .dec_q  (dec_q),
    .hist_q (hist_o)
  );

  assign dec_even_o = dec_q[0];
  assign dec_odd_o  = dec_q[1];

endmodule

// File: rtl/spec_dfe_chk.sv
module spec_dfe_chk #(
  parameter int unsigned COEF_W   = 8,
  parameter int unsigned NUM_TAPS = 5,
  parameter int unsigned LANES    = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                valid_i,
  input logic [COEF_W-1:0]   coef_h1,
  input logic                dec_even_o,
  input logic                dec_odd_o,
  input logic [NUM_TAPS-1:0] hist_o,
  input logic [LANES-1:0]    lane_up,
  input logic [LANES-1:0]    lane_dn,
  input logic [LANES-1:0]    lane_prev,
  input logic [LANES-1:0]    lane_dec
);

  // R1: a valid cycle registers the pair decided in that cycle.
  p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> (dec_even_o == $past(lane_dec[0]) && dec_odd_o == $past(lane_dec[1])));

  // R2: with a non-negative H1, the -H1 path passing implies the +H1 path passes.
  p_spec_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !coef_h1[COEF_W-1] |-> ((lane_up & ~lane_dn) == '0));

  // R3: the even half uses the last odd bit as its previous bit.
  p_even_prev_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lane_prev[0] == hist_o[0]);

  // R3: the odd half uses the even decision of the same pair.
  p_odd_prev_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lane_prev[1] == lane_dec[0]);

  // R5: history shifts by two, newest pair at the bottom.
  p_hist_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> (hist_o[NUM_TAPS-1:LANES] == $past(hist_o[NUM_TAPS-1-LANES:0])
                 && hist_o[0] == dec_odd_o && hist_o[1] == dec_even_o));

  // R6: nothing moves without the strobe.
  p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> ($stable(dec_even_o) && $stable(dec_odd_o) && $stable(hist_o)));

  // R7: reset clears decisions and history.
  p_reset_clear_r7: assert property (@(posedge clk)
    !rst_n |=> (hist_o == '0 && !dec_even_o && !dec_odd_o));

endmodule

bind spec_dfe_hr spec_dfe_chk #(
  .COEF_W   (COEF_W),
  .NUM_TAPS (NUM_TAPS),
  .LANES    (LANES)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .valid_i    (valid_i),
  .coef_h1    (coef_i[COEF_W-1:0]),
  .dec_even_o (dec_even_o),
  .dec_odd_o  (dec_odd_o),
  .hist_o     (hist_o),
  .lane_up    (lane_up),
  .lane_dn    (lane_dn),
  .lane_prev  (lane_prev),
  .lane_dec   (lane_dec)
);

// File: tb/spec_dfe_hr_tb_top.sv
`timescale 1ns/1ps
module spec_dfe_hr_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [7:0]  samp_even_i = '0;
  logic [7:0]  samp_odd_i = '0;
  logic [39:0] coef_i = '0;
  logic        dec_even_o;
  logic        dec_odd_o;
  logic [4:0]  hist_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  int       c [1:5];   // bench copy of the taps
  bit [4:0] mh;        // bench history, mh[j] = bit j+1 back from next even
  bit       me, mo;    // bench copy of the registered decisions

  always #2.5 clk = ~clk;

  spec_dfe_hr dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid_i     (valid_i),
    .samp_even_i (samp_even_i),
    .samp_odd_i  (samp_odd_i),
    .coef_i      (coef_i),
    .dec_even_o  (dec_even_o),
    .dec_odd_o   (dec_odd_o),
    .hist_o      (hist_o)
  );

  // Plain, non-speculative restatement: subtract every tap with the true past bit.
  function automatic bit ref_decide(int x, bit [4:0] p);
    int y;
    y = x;
    for (int k = 1; k <= 5; k++) y -= c[k] * (p[k-1] ? 1 : -1);
    return (y >= 0);
  endfunction

  task automatic check(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_coefs(int h1, int h2, int h3, int h4, int h5);
    c[1] = h1; c[2] = h2; c[3] = h3; c[4] = h4; c[5] = h5;
    coef_i = {h5[7:0], h4[7:0], h3[7:0], h2[7:0], h1[7:0]};
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; valid_i = 1'b0;
    mh = '0; me = 0; mo = 0;
    repeat (2) @(negedge clk);
    check("R7", {dec_even_o, dec_odd_o, hist_o}, 0);
    rst_n = 1'b1;
  endtask

  // One cycle of stimulus, then compare all outputs after the edge.
  task automatic step(string tag, bit v, int xe, int xo);
    bit e, o;
    @(negedge clk);
    valid_i = v;
    samp_even_i = xe[7:0];
    samp_odd_i  = xo[7:0];
    if (v) begin
      e  = ref_decide(xe, mh);
      o  = ref_decide(xo, {mh[3:0], e});
      mh = {mh[2:0], e, o};
      me = e; mo = o;
    end
    @(posedge clk);
    #1;
    check(tag, dec_even_o, me);
    check(tag, dec_odd_o, mo);
    check("R5", hist_o, mh);
  endtask

  function automatic int rnd8();
    int v;
    v = int'($urandom % 256);
    return (v > 127) ? v - 256 : v;
  endfunction

  initial begin
    void'($urandom(32'd20151));
    set_coefs(0, 0, 0, 0, 0);
    mh = '0; me = 0; mo = 0;
    repeat (3) @(negedge clk);
    check("R7", {dec_even_o, dec_odd_o, hist_o}, 0);
    rst_n = 1'b1;

    // R2: a zero sum slices to 1, minus one to 0.
    step("R2", 1, 0, -1);
    step("R2", 1, -1, 0);

    // R6: idle cycles with changing samples leave everything alone.
    step("R6", 0, 100, -100);
    step("R6", 0, -100, 100);

    // R3: only H1 set; the previous bit flips the outcome.
    do_reset();
    set_coefs(50, 0, 0, 0, 0);
    step("R3", 1, -40, -40);   // even: prev -1 -> 10 -> 1; odd: prev +1 -> -90 -> 0
    step("R3", 1, 40, -40);
    step("R3", 1, -50, 49);
    step("R3", 1, 60, 0);

    // R7 / R4: cleared history counts as -1 through the deepest tap.
    do_reset();
    set_coefs(0, 0, 0, 0, 100);
    step("R7", 1, -99, -101);
    step("R4", 1, 20, -20);
    step("R4", 1, -100, 100);
    step("R4", 1, 0, 0);

    // R4: second tap alone.
    set_coefs(0, 70, 0, 0, 0);
    step("R4", 1, -69, 69);
    step("R4", 1, -70, 70);
    step("R4", 1, 10, -10);

    // R8: full-scale extremes.
    set_coefs(-128, -128, -128, -128, -128);
    step("R8", 1, -128, -128);
    step("R8", 1, 127, -128);
    set_coefs(127, 127, 127, 127, 127);
    step("R8", 1, 127, 127);
    step("R8", 1, -128, 127);
    set_coefs(-128, 127, -128, 127, -128);
    step("R8", 1, -128, 127);

    // R1: random pairs, random taps, occasional idle cycles.
    for (int i = 0; i < 3000; i++) begin
      if (i % 64 == 0) set_coefs(rnd8(), rnd8() / 2, rnd8() / 2, rnd8() / 4, rnd8() / 4);
      step(((i % 5) == 4) ? "R6" : "R1", (i % 5) != 4, rnd8(), rnd8());
    end

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule